// File: doc/BRIEF.md
# Adaptive Output Window and Gain-Exponent Encoder

This block sits at the end of a channel-emulation filter. It turns each wide signed accumulator result into a 14-bit signed word for a digital-to-analog converter. In adaptive mode it does not always cut the same fixed top slice. Instead it shifts the sample right just far enough that its significant bits, sign bit included, fit the 14-bit window. In fixed mode it always takes the top 14 bits.

The shift is not chosen per sample, because the analog gain stage downstream updates slowly. Over a block of samples, marked by a block-end strobe, the block records the largest shift any sample would need. That value becomes the window for the next block. A sample that no longer fits the current window is clamped to full scale.

Alongside every output sample the block reports the shift it applied. It also reports a 9-bit scale word. The word combines the coefficient exponent and the smaller of the two input-channel exponents, minus the applied shift. An external amplifier uses it to restore the true amplitude.

Top module: `slide_trunc_scaler`

## Requirements
- R1: While reset is active and until the first accepted sample, out_valid is 0 and out_sample, out_shift and out_scale are all 0.
- R2: An accepted sample (in_valid high) produces out_valid high on the next cycle, with out_sample, out_shift and out_scale all derived from that same sample. A cycle without in_valid gives out_valid low on the next cycle.
- R3: With slide_en low (fixed mode) the applied shift is always 21, and out_sample equals in_sample arithmetically shifted right by 21.
- R4: With slide_en high, out_sample equals in_sample arithmetically shifted right by the current block shift. If that result lies outside [-8192, 8191], it is saturated to the nearest bound.
- R5: The shift a sample needs is the smallest s in 0..21 for which in_sample >>> s lies inside [-8192, 8191]. Sign-extension bits count the same way for negative and positive samples.
- R6: The block shift changes only on a cycle with blk_end high. It then becomes the largest need among the samples accepted since the previous blk_end, including a sample accepted in the strobe cycle itself. That sample is still windowed with the old block shift. After reset the block shift is 21.
- R7: A blk_end with no sample accepted since the previous blk_end sets the block shift to 0.
- R8: The input exponent used is the smaller of kx_a and kx_b.
- R9: With ASF = kh + min(kx_a, kx_b) - applied shift, out_scale[8] is 1 exactly when ASF > 0 (the gain stage must divide), and out_scale[7:0] = |ASF|. ASF = 0 gives an all-zero word.
- R10: out_shift equals the shift applied to the sample it accompanies, and never exceeds 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | in_sample carries a sample this cycle |
| in_sample | input | 35 | Signed accumulator result |
| kx_a | input | 3 | Gain exponent of input channel A |
| kx_b | input | 3 | Gain exponent of input channel B |
| kh | input | 4 | Coefficient scale exponent of the active profile |
| slide_en | input | 1 | 1 = adaptive window, 0 = fixed top-14-bit window |
| blk_end | input | 1 | Closes the current measurement block |
| out_valid | output | 1 | Outputs below belong to a new sample |
| out_sample | output | 14 | Signed windowed sample for the converter |
| out_shift | output | 5 | Right shift applied to this sample |
| out_scale | output | 9 | Direction bit and magnitude of the combined exponent |

## Verification
The checker watches, on every cycle, the one-cycle valid latency, the shift of 21 in fixed mode, and the rule that the block shift holds steady between strobes. It also checks the range of the reported shift and that no scale word encodes a negative zero. The bench scenarios are the only place that shows the exact windowed values and saturation at both bounds. They also cover the maximum-need rule across a block, including the sample taken on the strobe cycle, the collapse to zero after an empty block, and the arithmetic of the scale word against an independent model.

// File: rtl/trunc_pkg.sv
package trunc_pkg;
  typedef enum logic {
    TRUNC_FIXED = 1'b0,
    TRUNC_SLIDE = 1'b1
  } trunc_mode_e;
endpackage

// File: rtl/st_headroom.sv
// Counts redundant sign bits and turns them into the shift this sample needs.
module st_headroom #(
  parameter int IN_W    = 35,
  parameter int OUT_W   = 14,
  parameter int SHIFT_W = 5
) (
  input  logic [IN_W-1:0]    x,
  output logic [SHIFT_W-1:0] need
);
  localparam int FIX   = IN_W - OUT_W;
  localparam int CNT_W = $clog2(IN_W);

  logic [CNT_W-1:0] red;
  logic             run;

  always_comb begin
    red = '0;
    run = 1'b1;
    for (int i = IN_W - 2; i >= 0; i--) begin
      if (run && (x[i] == x[IN_W-1])) red = red + 1'b1;
      else                            run = 1'b0;
    end
    if (int'(red) >= FIX) need = '0;
    else                  need = SHIFT_W'(FIX - int'(red));
  end
endmodule

// File: rtl/st_block_ctrl.sv
// Tracks the peak need within a block and updates the block shift on the strobe.
module st_block_ctrl #(
  parameter int IN_W    = 35,
  parameter int OUT_W   = 14,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               sample_ok,
  input  logic               blk_end,
  input  logic [SHIFT_W-1:0] need,
  output logic [SHIFT_W-1:0] blk_shift
);
  localparam int FIX = IN_W - OUT_W;

  logic [SHIFT_W-1:0] peak_q, peak_d, peak_up;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic               en;

  always_comb begin
    peak_up = (sample_ok && (need > peak_q)) ? need : peak_q;
    en      = sample_ok | blk_end;
    if (blk_end) begin
      shift_d = peak_up;
      peak_d  = '0;
    end else begin
      shift_d = shift_q;
      peak_d  = peak_up;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      peak_q  <= '0;
      shift_q <= SHIFT_W'(FIX);
    end else if (en) begin
      peak_q  <= peak_d;
      shift_q <= shift_d;
    end
  end

  assign blk_shift = shift_q;
endmodule

// File: rtl/st_window.sv
// Arithmetic right shift followed by saturation into the output width.
module st_window #(
  parameter int IN_W    = 35,
  parameter int OUT_W   = 14,
  parameter int SHIFT_W = 5
) (
  input  logic [IN_W-1:0]    x,
  input  logic [SHIFT_W-1:0] shift,
  output logic [OUT_W-1:0]   y
);
  localparam int TOP_W = IN_W - OUT_W + 1;

  logic signed [IN_W-1:0] shifted;
  logic                   fits;

  always_comb begin
    shifted = $signed(x) >>> shift;
    fits    = (shifted[IN_W-1:OUT_W-1] == {TOP_W{shifted[IN_W-1]}});
    if (fits)                 y = shifted[OUT_W-1:0];
    else if (shifted[IN_W-1]) y = {1'b1, {(OUT_W-1){1'b0}}};
    else                      y = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/st_scale_enc.sv
// Combines the exponents into a direction bit plus magnitude.
module st_scale_enc #(
  parameter int KX_W    = 3,
  parameter int KH_W    = 4,
  parameter int SHIFT_W = 5,
  parameter int SCALE_W = 9
) (
  input  logic [KX_W-1:0]    kx_a,
  input  logic [KX_W-1:0]    kx_b,
  input  logic [KH_W-1:0]    kh,
  input  logic [SHIFT_W-1:0] shift,
  output logic [SCALE_W-1:0] word
);
  localparam int MAG_W = SCALE_W - 1;

  int kx_min, asf, mag;

  always_comb begin
    kx_min = (kx_a < kx_b) ? int'(kx_a) : int'(kx_b);
    asf    = int'(kh) + kx_min - int'(shift);
    mag    = (asf < 0) ? -asf : asf;
    word   = {(asf > 0), MAG_W'(mag)};
  end
endmodule

// File: rtl/slide_trunc_scaler.sv
module slide_trunc_scaler #(
  parameter int IN_W    = 35,
  parameter int OUT_W   = 14,
  parameter int KX_W    = 3,
  parameter int KH_W    = 4,
  parameter int SCALE_W = 9,
  localparam int SHIFT_W = $clog2(IN_W - OUT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_sample,
  input  logic [KX_W-1:0]    kx_a,
  input  logic [KX_W-1:0]    kx_b,
  input  logic [KH_W-1:0]    kh,
  input  logic               slide_en,
  input  logic               blk_end,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_sample,
  output logic [SHIFT_W-1:0] out_shift,
  output logic [SCALE_W-1:0] out_scale
);
  import trunc_pkg::*;

  localparam int FIX = IN_W - OUT_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  trunc_mode_e        mode;
  logic [SHIFT_W-1:0] need, blk_shift, applied;
  logic [OUT_W-1:0]   win;
  logic [SCALE_W-1:0] scale;

  assign mode    = trunc_mode_e'(slide_en);
  assign applied = (mode == TRUNC_SLIDE) ? blk_shift : SHIFT_W'(FIX);

  st_headroom #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_head (
    .x    (in_sample),
    .need (need)
  );

  st_block_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_ctrl (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sample_ok (in_valid),
    .blk_end   (blk_end),
    .need      (need),
    .blk_shift (blk_shift)
  );

  st_window #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_win (
    .x     (in_sample),
    .shift (applied),
    .y     (win)
  );

  st_scale_enc #(.KX_W(KX_W), .KH_W(KH_W), .SHIFT_W(SHIFT_W), .SCALE_W(SCALE_W)) u_enc (
    .kx_a  (kx_a),
    .kx_b  (kx_b),
    .kh    (kh),
    .shift (applied),
    .word  (scale)
  );

  // output stage: next-state and register split
  logic               vld_d;
  logic [OUT_W-1:0]   smp_d;
  logic [SHIFT_W-1:0] sft_d;
  logic [SCALE_W-1:0] scl_d;

  always_comb begin
    vld_d = in_valid;
    smp_d = in_valid ? win     : out_sample;
    sft_d = in_valid ? applied : out_shift;
    scl_d = in_valid ? scale   : out_scale;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_shift  <= '0;
      out_scale  <= '0;
    end else begin
      out_valid <= vld_d;
      if (in_valid) begin
        out_sample <= smp_d;
        out_shift  <= sft_d;
        out_scale  <= scl_d;
      end
    end
  end
endmodule

// File: rtl/slide_trunc_scaler_chk.sv
module slide_trunc_scaler_chk #(
  parameter int IN_W    = 35,
  parameter int OUT_W   = 14,
  parameter int SCALE_W = 9,
  parameter int SHIFT_W = 5
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               in_valid,
  input logic               slide_en,
  input logic               blk_end,
  input logic [SHIFT_W-1:0] blk_shift,
  input logic               out_valid,
  input logic [SHIFT_W-1:0] out_shift,
  input logic [SCALE_W-1:0] out_scale
);
  localparam int FIX   = IN_W - OUT_W;
  localparam int MAG_W = SCALE_W - 1;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> !out_valid);

  // R3
  fixed_shift_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !slide_en) |=> (int'(out_shift) == FIX));

  // R6
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !blk_end |=> $stable(blk_shift));

  // R9
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && (out_scale[MAG_W-1:0] == '0)) |-> !out_scale[SCALE_W-1]);

  // R10
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> (int'(out_shift) <= FIX));
endmodule

bind slide_trunc_scaler slide_trunc_scaler_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .in_valid  (in_valid),
  .slide_en  (slide_en),
  .blk_end   (blk_end),
  .blk_shift (blk_shift),
  .out_valid (out_valid),
  .out_shift (out_shift),
  .out_scale (out_scale)
);

// File: tb/slide_trunc_scaler_tb.sv
`timescale 1ns/1ps
module slide_trunc_scaler_tb;
  localparam int IN_W = 35;
  localparam int OUT_W = 14;
  localparam int FIX = 21;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [IN_W-1:0]    in_sample = '0;
  logic [2:0]         kx_a = '0, kx_b = '0;
  logic [3:0]         kh = '0;
  logic               slide_en = 1'b0, blk_end = 1'b0;
  logic               out_valid;
  logic [OUT_W-1:0]   out_sample;
  logic [4:0]         out_shift;
  logic [8:0]         out_scale;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  slide_trunc_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .kx_a(kx_a), .kx_b(kx_b), .kh(kh), .slide_en(slide_en), .blk_end(blk_end),
    .out_valid(out_valid), .out_sample(out_sample), .out_shift(out_shift),
    .out_scale(out_scale)
  );

  typedef struct {
    logic [OUT_W-1:0] y;
    logic [4:0]       s;
    logic [8:0]       w;
  } exp_t;
  exp_t q[$];

  // reference model state
  int m_shift = FIX;
  int m_peak  = 0;

  function automatic int need_of(longint v);
    for (int n = 1; n <= IN_W; n++) begin
      longint lim = longint'(1) << (n - 1);
      if (v >= -lim && v < lim) return (n > OUT_W) ? n - OUT_W : 0;
    end
    return FIX;
  endfunction

  function automatic logic [OUT_W-1:0] win_of(longint v, int s);
    longint r = v >>> s;
    if (r > 8191)  r = 8191;
    if (r < -8192) r = -8192;
    return OUT_W'(r);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(longint v, int ka, int kb, int h, bit slide, bit strobe);
    exp_t e;
    int   s, asf, kx;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = IN_W'(v);
    kx_a = 3'(ka); kx_b = 3'(kb); kh = 4'(h);
    slide_en = slide; blk_end = strobe;
    s   = slide ? m_shift : FIX;
    kx  = (ka < kb) ? ka : kb;
    asf = h + kx - s;
    e.y = win_of(v, s);
    e.s = 5'(s);
    e.w = {asf > 0, 8'((asf < 0) ? -asf : asf)};
    q.push_back(e);
    if (need_of(v) > m_peak) m_peak = need_of(v);
    if (strobe) begin m_shift = m_peak; m_peak = 0; end
  endtask

  task automatic idle(bit strobe);
    @(negedge clk);
    in_valid = 1'b0;
    blk_end  = strobe;
    if (strobe) begin m_shift = m_peak; m_peak = 0; end
  endtask

  // monitor: pops one expected item per produced sample (R2, R3, R4, R9, R10)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2 unexpected out_valid actual=1 expected=0");
      end else begin
        e = q.pop_front();
        check("R4 sample", 16'(out_sample), 16'(e.y));
        check("R10 shift", 16'(out_shift), 16'(e.s));
        check("R9 scale", 16'(out_scale), 16'(e.w));
      end
    end
  end

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 16'(out_valid), 16'd0);
    check("R1 sample", 16'(out_sample), 16'd0);
    check("R1 shift", 16'(out_shift), 16'd0);
    check("R1 scale", 16'(out_scale), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle valid", 16'(out_valid), 16'd0);

    // R3 fixed mode: top 14 bits, shift 21
    send(longint'(1) << 33, 2, 5, 0, 0, 0);
    send(-(longint'(1) << 34), 7, 7, 15, 0, 0);
    send(-5, 1, 4, 3, 0, 1);            // ends block, peak 21

    // R6: block shift after reset/fixed block is 21
    send(1000, 0, 0, 0, 1, 1);          // R8/R9 ASF=-21, block peak 0
    // R4/R5 block with shift 0, boundaries and saturation
    send(1000, 3, 6, 2, 1, 0);          // R8 min=3
    send(-8192, 7, 7, 15, 1, 0);        // R9 ASF=22 divide
    send(8191, 0, 0, 0, 1, 0);
    send(8192, 0, 0, 0, 1, 0);          // saturates to 8191
    send(-20000, 0, 0, 0, 1, 1);        // R6 strobe-cycle sample uses old shift
    // R6 new shift 2
    send(40000, 1, 3, 1, 1, 0);         // R9 ASF=0
    send(-40000, 2, 2, 1, 1, 0);
    send(longint'(1) << 30, 4, 6, 3, 1, 1);  // need 18
    send(longint'(1) << 30, 0, 1, 0, 1, 0);  // shift 18 -> 4096
    send(-(longint'(1) << 34), 0, 0, 0, 1, 0); // saturates low
    idle(1);                             // shift 21
    send(-(longint'(1) << 34), 0, 0, 0, 1, 0);
    idle(1);                             // peak 21 kept
    idle(1);                             // R7 empty block -> 0
    send(3, 5, 2, 9, 1, 0);
    send(-1, 7, 6, 0, 1, 0);
    idle(0);
    repeat (3) @(negedge clk);
    // R2: every sample produced exactly one output
    check("R2 drained", 16'(q.size()), 16'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule